// File: doc/BRIEF.md
# Sync Input Glitch Filter

This block cleans up a video sync line that arrives with slow, noisy edges before any counter or timing logic looks at it. The raw line is first brought into the system clock domain by a short flop chain. That chain can be left out by a parameter when the line already comes from the same clock. The synchronised value then walks through a shift register of voting stages.

The filtered level is a register with hysteresis. It goes to 1 only when every voting stage reads 1, goes to 0 only when every stage reads 0, and otherwise keeps its value. Any ringing or chatter whose runs are shorter than the voting depth therefore never reaches the output. A registered single-cycle pulse marks each rising edge of the filtered level, so downstream logic can use it as a synchronous enable. With the default depth of five stages the filter suits a clock of about 100 MHz, and slower clocks can use fewer stages.

Top module: `sync_glitch_filter`

## Requirements
- R1: With `RESYNC_EN`=1 the raw input passes through `RESYNC_DEPTH` (default 2) flops before the voting stages. With `RESYNC_EN`=0 those flops are absent and the latency shrinks by `RESYNC_DEPTH` cycles.
- R2: `sync_clean` changes from 0 to 1 only on a clock edge at which all `VOTE_DEPTH` (default 5) voting stages hold 1.
- R3: `sync_clean` changes from 1 to 0 only on a clock edge at which all voting stages hold 0.
- R4: While the voting stages hold a mix of ones and zeros, `sync_clean` keeps its value. Chatter on `sync_raw` made of runs shorter than `VOTE_DEPTH` cycles produces exactly one change of `sync_clean` per real level change, and none when the settled level equals the old one.
- R5: A clean step on `sync_raw`, held long enough, appears on `sync_clean` after exactly `RESYNC_DEPTH + VOTE_DEPTH + 1` rising clock edges (8 with defaults, 6 with resync bypassed), for both rising and falling steps.
- R6: `sync_rise` is active-high. It is 1 for exactly one cycle, on the clock edge after the one where `sync_clean` went from 0 to 1, and it fires once per rising edge of `sync_clean`.
- R7: While `rst` is 1 at a rising clock edge, every flop is cleared, so `sync_clean` and `sync_rise` read 0 after that edge.
- R8: A falling edge of `sync_clean` never produces a pulse on `sync_rise`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sync_raw | input | 1 | Raw, possibly asynchronous sync line |
| sync_clean | output | 1 | Filtered sync level with hysteresis |
| sync_rise | output | 1 | One-cycle pulse, one clock after each rising edge of `sync_clean` |

## Verification
A wrong voting stage or a miscounted chain shows at `sync_clean` as a latency that is off by one or more cycles on the first clean step. A filter that reacts to mixed patterns shows as an extra toggle of `sync_clean` inside the first chatter burst, within `RESYNC_DEPTH + VOTE_DEPTH + 1` cycles of it. A broken edge register shows on `sync_rise` one cycle after the filtered rise, as a missing pulse, a pulse two cycles long, or a pulse on a fall. The per-cycle reference model catches each of these in the cycle it happens.

// File: rtl/sync_glitch_pkg.sv
package sync_glitch_pkg;

  // Outcome of polling the voting stages in one cycle.
  typedef enum logic [1:0] {
    AGREE_NONE = 2'd0,
    AGREE_HIGH = 2'd1,
    AGREE_LOW  = 2'd2
  } agree_e;

  localparam int unsigned DEF_RESYNC_DEPTH = 2;
  localparam int unsigned DEF_VOTE_DEPTH   = 5;

  // Edges from an input step to the filtered level change.
  function automatic int unsigned step_latency(input bit resync_en,
                                               input int unsigned resync_depth,
                                               input int unsigned vote_depth);
    int unsigned front;
    front = resync_en ? resync_depth : 0;
    return front + vote_depth + 1;
  endfunction

endpackage

// File: rtl/sgf_resync.sv
module sgf_resync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[DEPTH-1];

  initial begin
    assert_depth_R1: assert (DEPTH >= 1);
  end
endmodule

// File: rtl/sgf_vote.sv
module sgf_vote
  import sync_glitch_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_VOTE_DEPTH
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   din,
  output logic   level,
  output agree_e agree
);
  logic [DEPTH-1:0] stages;

  function automatic agree_e poll(input logic [DEPTH-1:0] s);
    if (&s)       return AGREE_HIGH;
    else if (~|s) return AGREE_LOW;
    else          return AGREE_NONE;
  endfunction

  assign agree = poll(stages);

  always_ff @(posedge clk) begin
    if (rst) begin
      stages <= '0;
      level  <= 1'b0;
    end else begin
      stages[0] <= din;
      for (int i = 1; i < int'(DEPTH); i++) stages[i] <= stages[i-1];
      case (agree)
        AGREE_HIGH: level <= 1'b1;
        AGREE_LOW:  level <= 1'b0;
        default:    level <= level;
      endcase
    end
  end

  // Rise only after a unanimous high poll.
  assert_rise_unanimous_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(level) |-> $past(agree) == AGREE_HIGH);

  // Fall only after a unanimous low poll.
  assert_fall_unanimous_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(level) |-> $past(agree) == AGREE_LOW);

  // Mixed poll keeps the level.
  assert_mixed_holds_R4: assert property (@(posedge clk) disable iff (rst)
    agree == AGREE_NONE |=> $stable(level));
endmodule

// File: rtl/sgf_edge.sv
module sgf_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      level_d <= level;
      pulse   <= level & ~level_d;
    end
  end

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  assert_pulse_after_rise_R6: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ($past(level) && !$past(level, 2)));

  assert_no_pulse_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(level) |=> !pulse);
endmodule

// File: rtl/sync_glitch_filter.sv
module sync_glitch_filter
  import sync_glitch_pkg::*;
#(
  parameter bit          RESYNC_EN    = 1'b1,
  parameter int unsigned RESYNC_DEPTH = DEF_RESYNC_DEPTH,
  parameter int unsigned VOTE_DEPTH   = DEF_VOTE_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_raw,
  output logic sync_clean,
  output logic sync_rise
);
  localparam int unsigned LATENCY = step_latency(RESYNC_EN, RESYNC_DEPTH, VOTE_DEPTH);

  logic   in_sync;
  agree_e vote_state;

  if (RESYNC_EN) begin : g_resync
    sgf_resync #(.DEPTH(RESYNC_DEPTH)) u_resync (
      .clk  (clk),
      .rst  (rst),
      .din  (sync_raw),
      .dout (in_sync)
    );
  end else begin : g_bypass
    assign in_sync = sync_raw;
  end

  sgf_vote #(.DEPTH(VOTE_DEPTH)) u_vote (
    .clk   (clk),
    .rst   (rst),
    .din   (in_sync),
    .level (sync_clean),
    .agree (vote_state)
  );

  sgf_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sync_clean),
    .pulse (sync_rise)
  );

  initial begin
    assert_latency_R5: assert (LATENCY == VOTE_DEPTH + 1 + (RESYNC_EN ? RESYNC_DEPTH : 0));
  end

  assert_reset_clears_R7: assert property (@(posedge clk)
    $past(rst) |-> (!sync_clean && !sync_rise));
endmodule

// File: tb/sync_glitch_filter_bench.sv
module sync_glitch_filter_bench;
  localparam int RS = 2;
  localparam int VD = 5;

  function automatic int lat_of(input int front, input int depth);
    return front + depth + 1;
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic clean, rise, clean_b, rise_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sync_glitch_filter u_sync_glitch_filter (
    .clk(clk), .rst(rst), .sync_raw(raw), .sync_clean(clean), .sync_rise(rise));

  sync_glitch_filter #(.RESYNC_EN(1'b0)) u_sync_glitch_filter_bypass (
    .clk(clk), .rst(rst), .sync_raw(raw), .sync_clean(clean_b), .sync_rise(rise_b));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: raw history per edge, vote window, rise pulse.
  logic [15:0]   hist;
  logic          m_lvl, m_lvl_d, m_pulse;
  logic [VD-1:0] win;
  always @(posedge clk) begin
    if (rst) begin
      hist = '0; m_lvl = 1'b0; m_lvl_d = 1'b0; m_pulse = 1'b0;
    end else begin
      hist    = {hist[14:0], raw};
      m_pulse = m_lvl & ~m_lvl_d;
      m_lvl_d = m_lvl;
      win     = hist[RS+VD:RS+1];
      if (&win)       m_lvl = 1'b1;
      else if (~|win) m_lvl = 1'b0;
    end
  end

  int  obs_toggles = 0, obs_pulses = 0, exp_toggles = 0, exp_rises = 0;
  logic prev_clean = 1'b0;
  logic cur_level  = 1'b0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(clean == m_lvl, "R2,R3,R4 filtered level", clean, m_lvl);
      check(rise == m_pulse, "R6,R8 rise pulse", rise, m_pulse);
      if (clean != prev_clean) obs_toggles++;
      if (rise) obs_pulses++;
      prev_clean = clean;
    end
  end

  task automatic hold(input logic v, input int n);
    raw = v;
    repeat (n) @(negedge clk);
  endtask

  // Chatter made of runs shorter than VD, then a steady target level.
  task automatic segment(input logic target);
    int runs;
    logic v;
    runs = $urandom_range(1, 4);
    v = target;
    for (int r = 0; r < runs; r++) begin
      hold(v, $urandom_range(1, VD - 1));
      v = ~v;
    end
    hold(target, $urandom_range(RS + VD + 4, 30));
    if (target != cur_level) begin
      exp_toggles++;
      if (target) exp_rises++;
    end
    cur_level = target;
  endtask

  task automatic step_latency_check(input logic v);
    int t_main, t_byp;
    t_main = -1; t_byp = -1;
    raw = v;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (t_main < 0 && clean == v)   t_main = k;
      if (t_byp  < 0 && clean_b == v) t_byp  = k;
    end
    check(t_main == lat_of(RS, VD), "R5 step latency", t_main, lat_of(RS, VD));
    check(t_byp == lat_of(0, VD), "R1,R5 bypass latency", t_byp, lat_of(0, VD));
    exp_toggles++;
    if (v) exp_rises++;
    cur_level = v;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R7: reset holds outputs low even with the input high.
    raw = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check(clean == 1'b0 && clean_b == 1'b0, "R7 level in reset", clean, 0);
      check(rise == 1'b0 && rise_b == 1'b0, "R7 pulse in reset", rise, 0);
    end
    raw = 1'b0;
    rst = 1'b0;
    hold(1'b0, 12);
    // R5 and R1: exact latency, both directions.
    step_latency_check(1'b1);
    hold(1'b1, 5);
    step_latency_check(1'b0);
    hold(1'b0, 5);
    // R4: directed chatter, runs of VD-1 cycles.
    hold(1'b1, VD - 1); hold(1'b0, VD - 1); hold(1'b1, 1); hold(1'b0, 20);
    segment(1'b1);
    segment(1'b1);
    segment(1'b0);
    for (int s = 0; s < 300; s++) segment(($urandom_range(0, 2) != 0) ? ~cur_level : cur_level);
    hold(cur_level, 20);
    check(obs_toggles == exp_toggles, "R4 one change per real edge", obs_toggles, exp_toggles);
    check(obs_pulses == exp_rises, "R6 one pulse per rise", obs_pulses, exp_rises);
    // R7: reset mid-run with a high level.
    hold(1'b1, 20);
    rst = 1'b1;
    @(negedge clk);
    check(clean == 1'b0 && rise == 1'b0, "R7 reset clears", clean, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule